// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single line. Each frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. Between frames the line rests high. The clock runs at sixteen times the bit rate, so every bit lasts sixteen clock cycles.

A control word is latched from its own inputs on a configuration strobe. It holds four settings: the character length (5 to 8 bits), a parity inhibit, the parity sense (odd or even) and the stop length. Each character is written into a holding register with a load strobe. The block then moves it into the shift register as soon as the shifter is free. Because of this double buffering, software can queue the next character while the current frame is still on the line. Two flags report the state of the two registers: the holding register is empty, and the shifter is idle.

Top module: `async_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, `txd`, `hold_empty` and `line_idle` are all 1 until a character is loaded.
- R2: A frame begins with a start bit at 0 lasting 16 clock cycles. Every data and parity bit also lasts 16 cycles.
- R3: The `len_sel` code gives the data length: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Data bits go out least significant first, and the bits of `chr_in` above the selected length are never sent.
- R4: When `par_off` is 1, no parity slot is sent. Otherwise one parity bit follows the data. With `par_even` at 1, the data bits plus the parity bit hold an even number of ones. With `par_even` at 0, they hold an odd number.
- R5: The stop period is high. It lasts 16 cycles when `stop_long` is 0. When `stop_long` is 1 it lasts 32 cycles, except with 5-bit characters, where it lasts 24 cycles.
- R6: With no frame in progress, `line_idle` is 1 and `txd` is 1. When a character is loaded into an idle block, `line_idle` falls and the start bit begins two clock edges after the load strobe.
- R7: `hold_empty` falls on the clock edge that takes `chr_load`. It rises on the edge that moves the character into the shifter.
- R8: A character loaded while a frame is in progress waits in the holding register. Its start bit follows the last stop cycle directly, with no idle cycle in between, and `line_idle` stays 0 across the join.
- R9: The control word is taken only on `cfg_load`. A frame uses the control word held at the moment its character entered the shifter, so a control change during a frame first affects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at sixteen times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Strobe that latches the control fields |
| len_sel | input | 2 | Character length code (5 + code bits) |
| par_off | input | 1 | 1 inhibits the parity bit |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| stop_long | input | 1 | 1 selects the long stop period |
| chr_load | input | 1 | Strobe that writes `chr_in` into the holding register |
| chr_in | input | 8 | Parallel character |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register has no pending character |
| line_idle | output | 1 | Shift register has finished sending |

## Verification
The embedded assertions check the flag and line relations on every cycle. When the block is idle the line is high. A frame starts only from a pending character, and it starts with a low line. A load always empties the hold flag on the next cycle. The shifter goes idle only after a high stop cycle. Only the bench's scenarios can show the content and timing of a whole frame: the bit order, the masking of bits above the selected length, the parity value, the three stop durations, the seamless join of a queued character, and the rule that a control change reaches only the following frame.

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
  parameter int TICKS = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    len_sel,
  input  logic          par_off,
  input  logic          par_even,
  input  logic          stop_long,
  input  logic          chr_load,
  input  logic [DW-1:0] chr_in,
  output logic          txd,
  output logic          hold_empty,
  output logic          line_idle
);
  localparam int CW = $clog2(2*TICKS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] BIT_LAST  = CW'(TICKS-1);
  localparam logic [CW-1:0] ONE_STOP  = CW'(TICKS-1);
  localparam logic [CW-1:0] HALF_STOP = CW'(TICKS + TICKS/2 - 1);
  localparam logic [CW-1:0] TWO_STOP  = CW'(2*TICKS-1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    len_q;
  logic          poff_q, even_q, slong_q;
  logic [DW-1:0] hold_q, sh;
  logic          hold_full, f_poff, f_par;
  logic [IW-1:0] idx, last_idx;
  logic [CW-1:0] cnt, stop_end;

  logic [DW-1:0] mask;
  logic          bit_end, stop_done, take;

  assign mask      = {DW{1'b1}} >> (2'd3 - len_sel_q_w());
  assign bit_end   = (cnt == BIT_LAST);
  assign stop_done = (st == S_STOP) && (cnt == stop_end);
  assign take      = hold_full && ((st == S_IDLE) || stop_done);

  function automatic logic [1:0] len_sel_q_w();
    return len_q;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= 2'd3;
      poff_q  <= 1'b0;
      even_q  <= 1'b0;
      slong_q <= 1'b0;
    end else if (cfg_load) begin
      len_q   <= len_sel;
      poff_q  <= par_off;
      even_q  <= par_even;
      slong_q <= stop_long;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (take) hold_full <= 1'b0;
      if (chr_load) begin
        hold_q    <= chr_in;
        hold_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      idx      <= '0;
      last_idx <= '0;
      f_poff   <= 1'b0;
      f_par    <= 1'b0;
      stop_end <= ONE_STOP;
    end else if (take) begin
      st       <= S_START;
      cnt      <= '0;
      sh       <= hold_q & mask;
      idx      <= '0;
      last_idx <= IW'(len_q) + IW'(4);
      f_poff   <= poff_q;
      f_par    <= (^(hold_q & mask)) ^ ~even_q;
      stop_end <= !slong_q ? ONE_STOP : (len_q == 2'd0) ? HALF_STOP : TWO_STOP;
    end else begin
      case (st)
        S_START: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) st <= S_DATA;
        end
        S_DATA: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) begin
            if (idx == last_idx) st <= f_poff ? S_STOP : S_PAR;
            else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
            end
          end
        end
        S_PAR: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) st <= S_STOP;
        end
        S_STOP: begin
          if (stop_done) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_PAR:   txd = f_par;
      default: txd = 1'b1;
    endcase
  end

  assign hold_empty = !hold_full;
  assign line_idle  = (st == S_IDLE);

  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> txd);
  a_r6_start_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_idle) |-> !txd && $past(!hold_empty));
  a_r7_load_fills_hold: assert property (@(posedge clk) disable iff (!rst_n)
    chr_load |=> !hold_empty);
  a_r5_stop_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(txd));
  a_r2_start_from_idle_or_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && $past(st) != S_START) |-> $past(line_idle) || $past(txd));
endmodule

// File: tb/tb_async_frame_tx.sv
module tb_async_frame_tx;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, par_off = 0, par_even = 0, stop_long = 0, chr_load = 0;
  logic [1:0] len_sel = 0;
  logic [7:0] chr_in = 0;
  logic txd, hold_empty, line_idle;
  int tests = 0, fails = 0;
  bit done = 0;

  async_frame_tx dut (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .len_sel(len_sel),
    .par_off(par_off), .par_even(par_even), .stop_long(stop_long), .chr_load(chr_load),
    .chr_in(chr_in), .txd(txd), .hold_empty(hold_empty), .line_idle(line_idle));

  always #(CLK_NS/2) clk = ~clk;

  // {len_sel, par_off, par_even, stop_long, chr_in}
  localparam logic [12:0] VEC [0:7] = '{
    {2'd3, 1'b0, 1'b1, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'hF3},
    {2'd1, 1'b1, 1'b0, 1'b1, 8'h2C},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h7F},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h15},
    {2'd3, 1'b0, 1'b0, 1'b1, 8'h00},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h81},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'hFF}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [12:0] v); return 5 + int'(v[12:11]); endfunction
  function automatic int npar(input logic [12:0] v); return v[10] ? 0 : 1; endfunction
  function automatic int stop_cyc(input logic [12:0] v);
    if (!v[8]) return 16;
    return (v[12:11] == 2'd0) ? 24 : 32;
  endfunction
  function automatic int frame_cyc(input logic [12:0] v);
    return 16 * (1 + nbits(v) + npar(v)) + stop_cyc(v);
  endfunction
  function automatic logic slot_bit(input logic [12:0] v, input int s);
    int ones = 0;
    if (s == 0) return 1'b0;
    if (s <= nbits(v)) return v[s-1];
    for (int i = 0; i < nbits(v); i++) ones += int'(v[i]);
    if (s == nbits(v) + 1 && npar(v) == 1)
      return v[9] ? logic'(ones % 2) : logic'((ones % 2) == 0);
    return 1'b1;
  endfunction

  task automatic set_cfg(input logic [12:0] v);
    @(negedge clk);
    {len_sel, par_off, par_even, stop_long} = v[12:8];
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    {len_sel, par_off, par_even, stop_long} = ~v[12:8];
  endtask

  task automatic load_chr(input logic [7:0] d);
    chr_in = d;
    chr_load = 1;
    @(negedge clk);
    chr_load = 0;
    chr_in = ~d;
  endtask

  // Checks slots of frame v in busy cycle n (n = 1 is the first start cycle)
  task automatic check_slot(input logic [12:0] v, input int n);
    int slots = 1 + nbits(v) + npar(v);
    for (int s = 0; s < slots; s++)
      if (n == 16*s + 8) begin
        if (s == 0) chk(txd == 1'b0, "R2 start bit", txd, 0);
        else if (s <= nbits(v)) chk(txd == slot_bit(v, s), "R3 data bit", txd, slot_bit(v, s));
        else chk(txd == slot_bit(v, s), "R4 parity bit", txd, slot_bit(v, s));
      end
    if (n == 16*slots + 4 || n == frame_cyc(v))
      chk(txd == 1'b1, "R5 stop level", txd, 1);
  endtask

  task automatic send(input logic [12:0] v);
    int n = 1;
    set_cfg(v);
    load_chr(v[7:0]);
    chk(hold_empty == 1'b0, "R7 hold filled", hold_empty, 0);
    chk(line_idle == 1'b1, "R6 idle until transfer", line_idle, 1);
    @(negedge clk);
    chk(line_idle == 1'b0, "R6 frame started", line_idle, 0);
    chk(hold_empty == 1'b1, "R7 hold emptied", hold_empty, 1);
    while (!line_idle && n < 1000) begin
      check_slot(v, n);
      @(negedge clk);
      n++;
    end
    chk(n - 1 == frame_cyc(v), "R5 frame length", n - 1, frame_cyc(v));
    chk(txd == 1'b1, "R6 line high after frame", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [12:0] a, b;
    int n;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    chk(hold_empty && line_idle, "R1 flags in reset", {hold_empty, line_idle}, 3);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(txd && hold_empty && line_idle, "R1 after reset", {txd, hold_empty, line_idle}, 7);

    for (int k = 0; k < 8; k++) send(VEC[k]);

    // R8 and R9: queue a character and change the control word mid-frame
    a = {2'd3, 1'b0, 1'b1, 1'b0, 8'h5A};
    b = {2'd0, 1'b1, 1'b0, 1'b0, 8'hEC};
    set_cfg(a);
    load_chr(a[7:0]);
    @(negedge clk);
    n = 1;
    set_cfg(b); n += 2;
    load_chr(b[7:0]); n += 1;
    chk(hold_empty == 1'b0, "R8 queued char held", hold_empty, 0);
    while (n <= frame_cyc(a)) begin
      check_slot(a, n);
      @(negedge clk);
      n++;
    end
    chk(line_idle == 1'b0, "R8 no idle gap", line_idle, 0);
    chk(hold_empty == 1'b1, "R8 queued char moved", hold_empty, 1);
    n = 1;
    while (!line_idle && n < 1000) begin
      check_slot(b, n);
      @(negedge clk);
      n++;
    end
    chk(n - 1 == frame_cyc(b), "R9 new control on next frame", n - 1, frame_cyc(b));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule